// File: doc/BRIEF.md
# Byte Bit-Manipulation Execution Unit

This unit carries out one single-bit operation on a byte-wide operand for a small processor datapath. An operation names one bit of the byte, by a 3-bit index, and does one of two things with it. It can force, clear or flip that bit and produce the modified byte. It can instead read the bit and fold it into the zero flag or the carry flag, and the byte stays as it was. The index comes from an immediate field or from the low bits of a general register value. A combination the unit does not accept is reported by an error pulse.

The operand comes from one of two places. For a register operand the byte arrives on an input port, and the unit answers two clock edges after it accepts the start strobe. For a memory operand the unit runs a read-modify-write exchange over a request/acknowledge pair. It reads the byte, computes the new value, and writes it back only when the operation modifies the byte. The calling sequencer sees a single done pulse at the end. Result, write-back enable and both flags are valid in the cycle where done is high, and they hold until the next operation completes.

Top module: `bitop_unit`

## Requirements
- R1: Opcodes 0 (set), 1 (clear) and 2 (invert) force the selected bit of the operand to 1, to 0, or to its complement. All other bits of `result` equal the operand. `wb_en` is 1, and `c_out`/`z_out` equal `c_in`/`z_in` as sampled at start.
- R2: Opcode 3 (test) returns the operand unchanged in `result`, sets `z_out` to the inverse of the selected bit, keeps `c_out` equal to `c_in`, and drives `wb_en` to 0.
- R3: Opcodes 4, 5, 6 and 7 set `c_out` to C AND bit, C AND NOT bit, C OR bit and C OR NOT bit respectively. `z_out` equals `z_in`, `result` equals the operand, and `wb_en` is 0.
- R4: When `bit_from_reg` is 0 the bit index is `imm_bit`. When it is 1 the bit index is the low three bits of `bit_reg`, and the upper bits of `bit_reg` have no effect. Register sourcing is accepted for opcodes 0 to 3.
- R5: Opcodes 4 to 7 with `bit_from_reg`=1 are illegal. `err` pulses together with `done`, `result` equals `reg_opnd`, `c_out`/`z_out` equal the inputs, `wb_en` is 0, and no read or write request is raised even when `mem_op`=1.
- R6: With `mem_op`=0, `start` accepted at clock edge k gives `done` high exactly in the cycle after edge k+1. Operands, opcode, index and flags are sampled only at edge k.
- R7: With `mem_op`=1, `rd_req` rises after the start edge and stays high until `rd_ack` is seen. The operand is `rd_data` at the acknowledging edge, and `reg_opnd` is ignored.
- R8: For a memory operand with opcodes 0 to 2, `wr_req` rises one cycle after the read acknowledge. `wr_data` carries the modified byte and stays stable until `wr_ack`. `done` follows in the cycle after the acknowledging edge.
- R9: For a memory operand with opcodes 3 to 7, no write request is raised, and `done` is high in the second cycle after the read acknowledge.
- R10: `start` is ignored while `busy` is high, and `busy` is low in the cycle where `done` is high.
- R11: `done` and `err` are each one cycle wide, and `rd_req` and `wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code, 0 to 7 |
| mem_op | input | 1 | 1: operand is fetched over the read port; 0: operand is `reg_opnd` |
| bit_from_reg | input | 1 | 1: bit index from `bit_reg`; 0: from `imm_bit` |
| imm_bit | input | 3 | Immediate bit index |
| bit_reg | input | 8 | General register value whose low bits give the index |
| reg_opnd | input | 8 | Register operand byte |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| rd_req | output | 1 | Memory read request |
| rd_ack | input | 1 | Memory read acknowledge |
| rd_data | input | 8 | Memory read byte, valid with `rd_ack` |
| wr_req | output | 1 | Memory write request |
| wr_ack | input | 1 | Memory write acknowledge |
| wr_data | output | 8 | Byte to write back |
| result | output | 8 | Resulting byte |
| wb_en | output | 1 | Result must be written back |
| c_out | output | 1 | Updated carry flag |
| z_out | output | 1 | Updated zero flag |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-combination pulse |
| busy | output | 1 | Operation in progress |

## Verification
The hardest case to reach from the ports is a memory operation that stalls in a bus phase while new work arrives. A start strobe lands while the unit is still waiting for a read acknowledge, and a write request must stay stable over several cycles without an acknowledge. To reach it, the bench acts as the memory and delays each acknowledge by a programmed count. During the first wait cycle it pulses `start` with a different opcode and a register operand. It then checks that the read request never drops, that the written byte stays fixed, and that exactly one done pulse arrives carrying the first operation's result. The complete grid of opcode, bit index and both flag values also runs on register operands against a bench-side reference, using random bytes.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [2:0] {
    OP_SET   = 3'd0,
    OP_CLR   = 3'd1,
    OP_INV   = 3'd2,
    OP_TST   = 3'd3,
    OP_CAND  = 3'd4,
    OP_CANDN = 3'd5,
    OP_COR   = 3'd6,
    OP_CORN  = 3'd7
  } bitop_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  typedef struct packed {
    logic c;
    logic z;
  } flags_t;

endpackage

// File: rtl/bitop_rst_sync.sv
module bitop_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter  int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  bitop_e          op,
  input  logic            bit_from_reg,
  input  logic [BW-1:0]   imm_bit,
  input  logic [BW-1:0]   reg_low,
  output logic [BW-1:0]   bit_idx,
  output logic            illegal,
  output logic            modifies
);

  logic carry_class;

  // Carry-folding operations occupy the upper half of the opcode space.
  assign carry_class = (op == OP_CAND) || (op == OP_CANDN) ||
                       (op == OP_COR)  || (op == OP_CORN);

  always_comb begin
    bit_idx  = bit_from_reg ? reg_low : imm_bit;
    illegal  = carry_class && bit_from_reg;
    modifies = (op == OP_SET) || (op == OP_CLR) || (op == OP_INV);
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter  int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  bitop_e          op,
  input  logic [BW-1:0]   bit_idx,
  input  logic [DW-1:0]   opnd,
  input  flags_t          f_in,
  output logic [DW-1:0]   byte_out,
  output flags_t          f_out
);

  logic [DW-1:0] mask;
  logic          sel;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (bit_idx == BW'(i));
  end

  assign sel = |(opnd & mask);

  always_comb begin
    byte_out = opnd;
    f_out    = f_in;
    unique case (op)
      OP_SET:   byte_out = opnd | mask;
      OP_CLR:   byte_out = opnd & ~mask;
      OP_INV:   byte_out = opnd ^ mask;
      OP_TST:   f_out.z  = ~sel;
      OP_CAND:  f_out.c  = f_in.c & sel;
      OP_CANDN: f_out.c  = f_in.c & ~sel;
      OP_COR:   f_out.c  = f_in.c | sel;
      OP_CORN:  f_out.c  = f_in.c | ~sel;
      default:  byte_out = opnd;
    endcase
  end

endmodule

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   mem_op,
  input  logic   illegal,
  input  logic   mem_q,
  input  logic   mod_q,
  input  logic   rd_ack,
  input  logic   wr_ack,
  output logic   accept,
  output logic   rd_load,
  output logic   exec_fire,
  output logic   rd_req,
  output logic   wr_req,
  output logic   done_set,
  output logic   busy
);

  phase_e state_q;
  phase_e state_d;
  logic   needs_write;

  assign needs_write = mem_q && mod_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:  if (start) state_d = (mem_op && !illegal) ? PH_READ : PH_EXEC;
      PH_READ:  if (rd_ack) state_d = PH_EXEC;
      PH_EXEC:  state_d = needs_write ? PH_WRITE : PH_IDLE;
      PH_WRITE: if (wr_ack) state_d = PH_IDLE;
      default:  state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    accept    = (state_q == PH_IDLE) && start;
    rd_req    = (state_q == PH_READ);
    rd_load   = rd_req && rd_ack;
    exec_fire = (state_q == PH_EXEC);
    wr_req    = (state_q == PH_WRITE);
    done_set  = (exec_fire && !needs_write) || (wr_req && wr_ack);
    busy      = (state_q != PH_IDLE);
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter  int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic          mem_op,
  input  logic          bit_from_reg,
  input  logic [BW-1:0] imm_bit,
  input  logic [DW-1:0] bit_reg,
  input  logic [DW-1:0] reg_opnd,
  input  logic          c_in,
  input  logic          z_in,
  output logic          rd_req,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  input  logic          wr_ack,
  output logic [DW-1:0] wr_data,
  output logic [DW-1:0] result,
  output logic          wb_en,
  output logic          c_out,
  output logic          z_out,
  output logic          done,
  output logic          err,
  output logic          busy
);

  logic          rst_i_n;
  logic          accept, rd_load, exec_fire, done_set;
  logic [BW-1:0] idx_d;
  logic          ill_d, mod_d;
  logic          unused_hi;

  bitop_e        op_q;
  logic [BW-1:0] idx_q;
  logic          ill_q, mod_q, mem_q;
  flags_t        flags_q;
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] opnd_d;
  logic          opnd_en;

  logic [DW-1:0] alu_byte;
  flags_t        alu_flags;

  logic [DW-1:0] result_q;
  flags_t        fout_q;
  logic          wb_q, done_q, err_q;

  assign unused_hi = ^bit_reg[DW-1:BW];

  bitop_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bitop_decode #(.DW(DW)) u_dec (
    .op           (bitop_e'(op)),
    .bit_from_reg (bit_from_reg),
    .imm_bit      (imm_bit),
    .reg_low      (bit_reg[BW-1:0]),
    .bit_idx      (idx_d),
    .illegal      (ill_d),
    .modifies     (mod_d)
  );

  bitop_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (start),
    .mem_op    (mem_op),
    .illegal   (ill_d),
    .mem_q     (mem_q),
    .mod_q     (mod_q),
    .rd_ack    (rd_ack),
    .wr_ack    (wr_ack),
    .accept    (accept),
    .rd_load   (rd_load),
    .exec_fire (exec_fire),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .done_set  (done_set),
    .busy      (busy)
  );

  // Command capture, enabled by accept.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q    <= OP_SET;
      idx_q   <= '0;
      ill_q   <= 1'b0;
      mod_q   <= 1'b0;
      mem_q   <= 1'b0;
      flags_q <= '0;
    end else if (accept) begin
      op_q    <= bitop_e'(op);
      idx_q   <= idx_d;
      ill_q   <= ill_d;
      mod_q   <= mod_d && !ill_d;
      mem_q   <= mem_op && !ill_d;
      flags_q <= '{c: c_in, z: z_in};
    end
  end

  // Operand register: loaded from the register port at accept, or from
  // the read port at the acknowledging edge.
  always_comb begin
    opnd_en = accept || rd_load;
    opnd_d  = rd_load ? rd_data : reg_opnd;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     opnd_q <= '0;
    else if (opnd_en) opnd_q <= opnd_d;
  end

  bitop_alu #(.DW(DW)) u_alu (
    .op       (op_q),
    .bit_idx  (idx_q),
    .opnd     (opnd_q),
    .f_in     (flags_q),
    .byte_out (alu_byte),
    .f_out    (alu_flags)
  );

  // Result registers, enabled in the execute phase.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      result_q <= '0;
      fout_q   <= '0;
      wb_q     <= 1'b0;
    end else if (exec_fire) begin
      result_q <= ill_q ? opnd_q  : alu_byte;
      fout_q   <= ill_q ? flags_q : alu_flags;
      wb_q     <= mod_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_set;
      err_q  <= exec_fire && ill_q;
    end
  end

  assign wr_data = result_q;
  assign result  = result_q;
  assign wb_en   = wb_q;
  assign c_out   = fout_q.c;
  assign z_out   = fout_q.z;
  assign done    = done_q;
  assign err     = err_q;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          rd_ack,
  input logic          wr_req,
  input logic          wr_ack,
  input logic [DW-1:0] wr_data,
  input logic          wb_en,
  input logic          done,
  input logic          err,
  input logic          busy
);

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req);

  p_rd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req);

  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_data));

  p_done_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack |=> done && !wr_req);

  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !wb_en);

  p_idle_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  p_req_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

endmodule

bind bitop_unit bitop_unit_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_req  (rd_req),
  .rd_ack  (rd_ack),
  .wr_req  (wr_req),
  .wr_ack  (wr_ack),
  .wr_data (wr_data),
  .wb_en   (wb_en),
  .done    (done),
  .err     (err),
  .busy    (busy)
);

// File: tb/bitop_unit_tb.sv
`timescale 1ns/1ps
module bitop_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, mem_op, bit_from_reg, c_in, z_in, rd_ack, wr_ack;
  logic [2:0] op, imm_bit;
  logic [7:0] bit_reg, reg_opnd, rd_data;
  logic       rd_req, wr_req, wb_en, c_out, z_out, done, err, busy;
  logic [7:0] wr_data, result;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bitop_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .mem_op(mem_op),
    .bit_from_reg(bit_from_reg), .imm_bit(imm_bit), .bit_reg(bit_reg),
    .reg_opnd(reg_opnd), .c_in(c_in), .z_in(z_in), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req), .wr_ack(wr_ack),
    .wr_data(wr_data), .result(result), .wb_en(wb_en), .c_out(c_out),
    .z_out(z_out), .done(done), .err(err), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference from the requirements: opcodes 0..7 = set, clear, invert,
  // test, C&b, C&~b, C|b, C|~b.
  task automatic model(input logic [2:0] o, input logic [2:0] b, input logic [7:0] x,
                       input logic c, input logic z,
                       output logic [7:0] y, output logic co, output logic zo,
                       output logic wb);
    logic bv;
    bv = x[b];
    y = x; co = c; zo = z; wb = 1'b0;
    case (o)
      3'd0: begin y[b] = 1'b1; wb = 1'b1; end
      3'd1: begin y[b] = 1'b0; wb = 1'b1; end
      3'd2: begin y[b] = ~bv;  wb = 1'b1; end
      3'd3: zo = ~bv;
      3'd4: co = c & bv;
      3'd5: co = c & ~bv;
      3'd6: co = c | bv;
      default: co = c | ~bv;
    endcase
  endtask

  function automatic string tag_of(input logic [2:0] o);
    if (o < 3'd3) return "R1";
    if (o == 3'd3) return "R2";
    return "R3";
  endfunction

  task automatic idle_inputs();
    start = 0; op = 0; mem_op = 0; bit_from_reg = 0; imm_bit = 0;
    bit_reg = 0; reg_opnd = 0; c_in = 0; z_in = 0;
    rd_ack = 0; rd_data = 0; wr_ack = 0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("reset done", done, 0);
    chk("reset err", err, 0);
    chk("reset rd_req", rd_req, 0);
    chk("reset wr_req", wr_req, 0);
    chk("reset busy", busy, 0);
    chk("reset wb_en", wb_en, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("after reset busy", busy, 0);
  endtask

  // Register-operand (or illegal) operation; done expected two edges after start.
  task automatic run_reg(input string tag, input logic [2:0] o, input logic src_reg,
                         input logic [2:0] imm, input logic [7:0] rv,
                         input logic [7:0] x, input logic c, input logic z,
                         input logic mem);
    logic [7:0] ey; logic ec, ez, ewb, ill;
    logic [2:0] b;
    ill = (o >= 3'd4) && src_reg;
    b = src_reg ? rv[2:0] : imm;
    model(o, b, x, c, z, ey, ec, ez, ewb);
    if (ill) begin ey = x; ec = c; ez = z; ewb = 0; end
    @(negedge clk);
    start = 1; op = o; bit_from_reg = src_reg; imm_bit = imm; bit_reg = rv;
    reg_opnd = x; c_in = c; z_in = z; mem_op = mem;
    @(negedge clk);
    start = 0; reg_opnd = ~x; c_in = ~c; z_in = ~z; imm_bit = ~imm; bit_reg = ~rv;
    chk({tag, " R6 done early"}, done, 0);
    chk({tag, " R5 no read"}, rd_req, 0);
    @(negedge clk);
    chk({tag, " R6 done"}, done, 1);
    chk({tag, " result"}, result, ey);
    chk({tag, " c_out"}, c_out, ec);
    chk({tag, " z_out"}, z_out, ez);
    chk({tag, " wb_en"}, wb_en, ewb);
    chk({tag, " err"}, err, ill);
    chk({tag, " R5 no bus"}, {rd_req, wr_req}, 0);
    @(negedge clk);
    chk({tag, " R11 done width"}, done, 0);
    chk({tag, " R11 err width"}, err, 0);
  endtask

  task automatic run_mem(input logic [2:0] o, input logic [2:0] b, input logic [7:0] m,
                         input logic c, input logic z, input int rdly, input int wdly,
                         input logic poke);
    logic [7:0] ey; logic ec, ez, ewb;
    string t;
    t = tag_of(o);
    model(o, b, m, c, z, ey, ec, ez, ewb);
    @(negedge clk);
    start = 1; op = o; mem_op = 1; bit_from_reg = 0; imm_bit = b;
    reg_opnd = ~m; c_in = c; z_in = z;
    @(negedge clk);
    start = 0; imm_bit = ~b; c_in = ~c; z_in = ~z; mem_op = 0;
    chk("R7 rd_req raised", rd_req, 1);
    for (int i = 0; i < rdly; i++) begin
      if (poke && i == 0) begin start = 1; op = 3'd0; mem_op = 0; reg_opnd = 8'h00; end
      @(negedge clk);
      start = 0;
      chk("R7 rd_req held", rd_req, 1);
      chk("R11 no write in read", wr_req, 0);
    end
    rd_ack = 1; rd_data = m;
    @(negedge clk);
    rd_ack = 0; rd_data = ~m;
    chk("R7 rd_req dropped", rd_req, 0);
    chk("R7 no done yet", done, 0);
    @(negedge clk);
    if (ewb) begin
      chk("R8 wr_req raised", wr_req, 1);
      chk("R8 wr_data", wr_data, ey);
      chk("R8 no early done", done, 0);
      for (int i = 0; i < wdly; i++) begin
        @(negedge clk);
        chk("R8 wr_req held", wr_req, 1);
        chk("R8 wr_data stable", wr_data, ey);
      end
      wr_ack = 1;
      @(negedge clk);
      wr_ack = 0;
      chk("R8 done after wr_ack", done, 1);
      chk("R8 wr_req dropped", wr_req, 0);
    end else begin
      chk("R9 no write", wr_req, 0);
      chk("R9 done", done, 1);
    end
    chk({t, " R7 mem result"}, result, ey);
    chk({t, " mem c_out"}, c_out, ec);
    chk({t, " mem z_out"}, z_out, ez);
    chk({t, " mem wb_en"}, wb_en, ewb);
    chk("R10 idle at done", busy, 0);
    @(negedge clk);
    chk("R11 done width mem", done, 0);
    if (poke) chk("R10 start while busy ignored", {busy, rd_req}, 0);
  endtask

  task automatic t_grid();
    for (int o = 0; o < 8; o++)
      for (int b = 0; b < 8; b++)
        for (int f = 0; f < 4; f++)
          run_reg(tag_of(3'(o)), 3'(o), 1'b0, 3'(b), 8'($urandom), 8'($urandom),
                  f[1], f[0], 1'b0);
  endtask

  task automatic t_reg_source();
    for (int o = 0; o < 4; o++)
      for (int k = 0; k < 8; k++)
        run_reg("R4", 3'(o), 1'b1, 3'(k + 3), {5'($urandom), 3'(k)},
                8'($urandom), k[0], k[1], 1'b0);
  endtask

  task automatic t_illegal();
    for (int o = 4; o < 8; o++) begin
      run_reg("R5 reg", 3'(o), 1'b1, 3'd2, 8'($urandom), 8'h5A, 1'b1, 1'b0, 1'b0);
      run_reg("R5 mem", 3'(o), 1'b1, 3'd6, 8'($urandom), 8'hC3, 1'b0, 1'b1, 1'b1);
    end
  endtask

  task automatic t_memory();
    run_mem(3'd0, 3'd7, 8'h00, 1'b0, 1'b1, 0, 0, 1'b0);
    run_mem(3'd1, 3'd0, 8'hFF, 1'b1, 1'b0, 2, 3, 1'b0);
    run_mem(3'd2, 3'd4, 8'hA5, 1'b0, 1'b0, 1, 1, 1'b0);
    run_mem(3'd3, 3'd5, 8'h20, 1'b1, 1'b1, 3, 0, 1'b0);
    run_mem(3'd5, 3'd1, 8'h02, 1'b1, 1'b0, 0, 0, 1'b0);
    run_mem(3'd7, 3'd6, 8'h00, 1'b0, 1'b1, 2, 0, 1'b0);
  endtask

  task automatic t_busy_ignore();
    run_mem(3'd2, 3'd3, 8'h0F, 1'b1, 1'b1, 3, 2, 1'b1);
    run_mem(3'd6, 3'd3, 8'h08, 1'b0, 1'b0, 2, 0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_grid();
    t_reg_source();
    t_illegal();
    t_memory();
    t_busy_ignore();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule